// File: doc/BRIEF.md
# Interleaved Three-Channel Timer Register Bank

This block is the software-visible register file that sits in front of three timer channel cores. A simple request bus carries 32-bit word reads and writes. Each kind of register occupies one 12-byte group of three consecutive words, one word per channel. The channel is therefore the word address modulo the channel count, and the register kind is the word address divided by it. The bank keeps every configuration field for every channel and drives those fields out to the cores. It returns the live counter and event counts that the cores supply, and it keeps a per-channel interrupt status that the cores set and that a read clears.

The bank raises one interrupt line per channel whenever a status bit and its enable bit are both set. A write to a channel's counter-control word with the reset bit set produces a one-cycle reset pulse toward that channel's core. The reset bit itself is never stored. Read data is registered and comes back one cycle after the request.

Top module: `itm_regbank`

## Requirements
- R1: The word index is byte address bits [11:2]. The channel is word mod 3 and the register kind is word div 3. Kinds in ascending order are: clock control, counter control, live count, interval, match 1, match 2, match 3, interrupt status, interrupt enable, event control, event count. A write to one channel's word leaves the other channels' words of the same kind unchanged.
- R2: Written values are masked on storage: clock control keeps bits [5:0], counter control keeps bits [5:0] with bit 4 forced to 0 (mask 0x2F), interval and the three match words keep bits [15:0], interrupt enable keeps bits [5:0], and event control keeps bits [2:0].
- R3: After reset, every counter-control word reads 0x21, every other stored word reads 0, all interrupt lines are low, and no response or reset pulse is active.
- R4: An accepted read (valid with write low) returns its data on rsp_rdata with rsp_valid high in the following cycle. rsp_valid is low in any cycle that does not follow an accepted read.
- R5: A read of a channel's interrupt status returns the current 6-bit status and clears it in the same cycle. The channel's interrupt line updates accordingly, and a second read returns 0.
- R6: A status bit set by the channel core in the same cycle as a clearing read of that channel is kept. The read returns the old value and the next read returns the new bit.
- R7: Each channel's interrupt line is high exactly when the bitwise AND of its status and its interrupt enable is non-zero.
- R8: Writes to the live count, interrupt status and event count words, and to unmapped addresses, change no stored register and no output.
- R9: Reads beyond the last mapped word (byte offset 0x84 and up) return 0. The live count and event count read as the channel core's 16-bit value, zero-extended.
- R10: A write to a channel's counter-control word with bit 4 set raises that channel's cnt_rst_o bit for exactly the cycle after the write, and bit 4 reads back as 0.
- R11: The configuration outputs always show the stored clock control, counter control, interval, match and event control words of each channel, and they change only after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present, always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Registered read data |
| cnt_val_i | input | 48 | Live count per channel, 16 bits each, channel 0 in the low bits |
| evt_cnt_i | input | 48 | Event count per channel, 16 bits each |
| sts_set_i | input | 18 | Status set pulses from the cores, 6 bits per channel |
| clk_cfg_o | output | 18 | Clock control per channel, 6 bits each |
| ctl_cfg_o | output | 18 | Counter control per channel, 6 bits each |
| intv_o | output | 48 | Interval per channel, 16 bits each |
| match_o | output | 144 | Match words, 16 bits at offset (channel*3+index)*16 |
| evc_o | output | 9 | Event control per channel, 3 bits each |
| cnt_rst_o | output | 3 | One-cycle counter reset pulse per channel |
| irq_o | output | 3 | Interrupt line per channel |

## Verification
The cycle that matters most is the one in which a core sets a status bit while software reads and clears that same channel's status. The bench drives the set pulse on the same edge as the status read. It then judges the outcome in two steps: the read must return only the older bit, and a second read must return the newly set bit. A second overlap comes from a counter-control write. In that cycle the stored control word changes and a reset pulse is issued together. The bench checks the pulse in the cycle after the write and its absence one cycle later, and it reads the stored word back with bit 4 clear.

// File: rtl/itm_pkg.sv
package itm_pkg;

    localparam int unsigned CLK_W   = 6;
    localparam int unsigned CTL_W   = 6;
    localparam int unsigned STS_W   = 6;
    localparam int unsigned IEN_W   = 6;
    localparam int unsigned EVC_W   = 3;
    localparam int unsigned MATCH_N = 3;
    localparam int unsigned KIND_N  = 11;

    localparam logic [CTL_W-1:0] CTL_MASK    = 6'h2F;
    localparam logic [CTL_W-1:0] CTL_RESET   = 6'h21;
    localparam int unsigned      CTL_RST_BIT = 4;

    typedef enum logic [3:0] {
        K_CLK  = 4'd0,
        K_CTL  = 4'd1,
        K_CNT  = 4'd2,
        K_INTV = 4'd3,
        K_MAT1 = 4'd4,
        K_MAT2 = 4'd5,
        K_MAT3 = 4'd6,
        K_STS  = 4'd7,
        K_IEN  = 4'd8,
        K_EVC  = 4'd9,
        K_EVN  = 4'd10,
        K_NONE = 4'd15
    } reg_kind_e;

    typedef struct packed {
        logic [CLK_W-1:0] clk;
        logic [CTL_W-1:0] ctl;
        logic [IEN_W-1:0] ien;
        logic [EVC_W-1:0] evc;
    } chan_ctrl_t;

    function automatic chan_ctrl_t ctrl_reset_value();
        chan_ctrl_t v;
        v.clk = '0;
        v.ctl = CTL_RESET;
        v.ien = '0;
        v.evc = '0;
        return v;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_store(input logic [CTL_W-1:0] raw);
        return raw & CTL_MASK;
    endfunction

endpackage

// File: rtl/itm_decode.sv
module itm_decode
    import itm_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 12,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              hit_o
);

    localparam int unsigned WORD_W  = ADDR_W - 2;
    localparam int unsigned MAPPED  = KIND_N * NUM_CH;
    localparam bit          POW2_CH = (NUM_CH > 1) && ((NUM_CH & (NUM_CH - 1)) == 0);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] kind_idx;
    logic [CH_W-1:0]   ch_raw;

    assign word = addr[ADDR_W-1:2];

    generate
        if (POW2_CH) begin : g_shift
            assign ch_raw   = word[CH_W-1:0];
            assign kind_idx = word >> CH_W;
        end else begin : g_divide
            assign ch_raw   = CH_W'(word % WORD_W'(NUM_CH));
            assign kind_idx = word / WORD_W'(NUM_CH);
        end
    endgenerate

    assign hit_o  = (32'(word) < MAPPED);
    assign ch_o   = hit_o ? ch_raw : '0;
    assign kind_o = hit_o ? reg_kind_e'(kind_idx[3:0]) : K_NONE;

endmodule

// File: rtl/itm_chan.sv
module itm_chan
    import itm_pkg::*;
#(
    parameter int unsigned VAL_W = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  reg_kind_e                     kind,
    input  logic [VAL_W-1:0]              wdata,
    input  logic                          rd_clr,
    input  logic [STS_W-1:0]              sts_set,
    output chan_ctrl_t                    ctrl,
    output logic [VAL_W-1:0]              intv,
    output logic [MATCH_N-1:0][VAL_W-1:0] match,
    output logic [STS_W-1:0]              sts,
    output logic                          irq,
    output logic                          rst_pulse
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= ctrl_reset_value();
            intv      <= '0;
            match     <= '0;
            rst_pulse <= 1'b0;
        end else begin
            rst_pulse <= 1'b0;
            if (wr_en) begin
                case (kind)
                    K_CLK:  ctrl.clk <= wdata[CLK_W-1:0];
                    K_CTL: begin
                        ctrl.ctl  <= ctl_store(wdata[CTL_W-1:0]);
                        rst_pulse <= wdata[CTL_RST_BIT];
                    end
                    K_INTV: intv     <= wdata;
                    K_MAT1: match[0] <= wdata;
                    K_MAT2: match[1] <= wdata;
                    K_MAT3: match[2] <= wdata;
                    K_IEN:  ctrl.ien <= wdata[IEN_W-1:0];
                    K_EVC:  ctrl.evc <= wdata[EVC_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    // Clear and set in one cycle: a new event survives the clearing read.
    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            sts <= (rd_clr ? '0 : sts) | sts_set;
        end
    end

    assign irq = |(sts & ctrl.ien);

endmodule

// File: rtl/itm_regbank.sv
module itm_regbank
    import itm_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              req_valid,
    input  logic                              req_write,
    input  logic [ADDR_W-1:0]                 req_addr,
    input  logic [DATA_W-1:0]                 req_wdata,
    output logic                              rsp_valid,
    output logic [DATA_W-1:0]                 rsp_rdata,
    input  logic [NUM_CH*VAL_W-1:0]           cnt_val_i,
    input  logic [NUM_CH*VAL_W-1:0]           evt_cnt_i,
    input  logic [NUM_CH*STS_W-1:0]           sts_set_i,
    output logic [NUM_CH*CLK_W-1:0]           clk_cfg_o,
    output logic [NUM_CH*CTL_W-1:0]           ctl_cfg_o,
    output logic [NUM_CH*VAL_W-1:0]           intv_o,
    output logic [NUM_CH*MATCH_N*VAL_W-1:0]   match_o,
    output logic [NUM_CH*EVC_W-1:0]           evc_o,
    output logic [NUM_CH-1:0]                 cnt_rst_o,
    output logic [NUM_CH-1:0]                 irq_o
);

    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_kind_e       dec_kind;
    logic [CH_W-1:0] dec_ch;
    logic            dec_hit;
    logic            rd_accept;
    logic            wr_accept;
    logic [DATA_W-1:0] rd_next;

    chan_ctrl_t                    ctrl_a  [NUM_CH];
    logic [VAL_W-1:0]              intv_a  [NUM_CH];
    logic [MATCH_N-1:0][VAL_W-1:0] match_a [NUM_CH];
    logic [STS_W-1:0]              sts_a   [NUM_CH];
    logic [NUM_CH-1:0]             wr_en;
    logic [NUM_CH-1:0]             rd_clr;

    logic unused_bits;
    assign unused_bits = ^{req_wdata[DATA_W-1:VAL_W], req_addr[1:0]};

    assign rd_accept = req_valid && !req_write;
    assign wr_accept = req_valid && req_write;

    itm_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) i_decode (
        .addr   (req_addr),
        .kind_o (dec_kind),
        .ch_o   (dec_ch),
        .hit_o  (dec_hit)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
            assign wr_en[c]  = wr_accept && dec_hit && (32'(dec_ch) == c);
            assign rd_clr[c] = rd_accept && dec_hit && (dec_kind == K_STS)
                               && (32'(dec_ch) == c);

            itm_chan #(
                .VAL_W (VAL_W)
            ) i_chan (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (wr_en[c]),
                .kind      (dec_kind),
                .wdata     (req_wdata[VAL_W-1:0]),
                .rd_clr    (rd_clr[c]),
                .sts_set   (sts_set_i[c*STS_W +: STS_W]),
                .ctrl      (ctrl_a[c]),
                .intv      (intv_a[c]),
                .match     (match_a[c]),
                .sts       (sts_a[c]),
                .irq       (irq_o[c]),
                .rst_pulse (cnt_rst_o[c])
            );

            assign clk_cfg_o[c*CLK_W +: CLK_W] = ctrl_a[c].clk;
            assign ctl_cfg_o[c*CTL_W +: CTL_W] = ctrl_a[c].ctl;
            assign evc_o[c*EVC_W +: EVC_W]     = ctrl_a[c].evc;
            assign intv_o[c*VAL_W +: VAL_W]    = intv_a[c];
            for (genvar m = 0; m < MATCH_N; m++) begin : g_match
                assign match_o[(c*MATCH_N+m)*VAL_W +: VAL_W] = match_a[c][m];
            end
        end
    endgenerate

    always_comb begin
        rd_next = '0;
        if (dec_hit) begin
            case (dec_kind)
                K_CLK:  rd_next = DATA_W'(ctrl_a[dec_ch].clk);
                K_CTL:  rd_next = DATA_W'(ctrl_a[dec_ch].ctl);
                K_CNT:  rd_next = DATA_W'(cnt_val_i[dec_ch*VAL_W +: VAL_W]);
                K_INTV: rd_next = DATA_W'(intv_a[dec_ch]);
                K_MAT1: rd_next = DATA_W'(match_a[dec_ch][0]);
                K_MAT2: rd_next = DATA_W'(match_a[dec_ch][1]);
                K_MAT3: rd_next = DATA_W'(match_a[dec_ch][2]);
                K_STS:  rd_next = DATA_W'(sts_a[dec_ch]);
                K_IEN:  rd_next = DATA_W'(ctrl_a[dec_ch].ien);
                K_EVC:  rd_next = DATA_W'(ctrl_a[dec_ch].evc);
                K_EVN:  rd_next = DATA_W'(evt_cnt_i[dec_ch*VAL_W +: VAL_W]);
                default: rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_accept;
            if (rd_accept) begin
                rsp_rdata <= rd_next;
            end
        end
    end

endmodule

// File: rtl/itm_regbank_chk.sv
module itm_regbank_chk
    import itm_pkg::*;
#(
    parameter int unsigned NUM_CH = 3,
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned VAL_W  = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            req_valid,
    input logic                            req_write,
    input logic [ADDR_W-1:0]               req_addr,
    input logic                            rsp_valid,
    input logic [DATA_W-1:0]               rsp_rdata,
    input logic [NUM_CH*CLK_W-1:0]         clk_cfg_o,
    input logic [NUM_CH*CTL_W-1:0]         ctl_cfg_o,
    input logic [NUM_CH*VAL_W-1:0]         intv_o,
    input logic [NUM_CH*MATCH_N*VAL_W-1:0] match_o,
    input logic [NUM_CH*EVC_W-1:0]         evc_o,
    input logic [NUM_CH-1:0]               cnt_rst_o
);

    localparam int unsigned MAPPED = KIND_N * NUM_CH;

    a_r4_rsp_follows_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write) |=> rsp_valid);

    a_r4_quiet_otherwise: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_write) |=> !rsp_valid);

    a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && (32'(req_addr[ADDR_W-1:2]) >= MAPPED))
        |=> (rsp_rdata == '0));

    a_r10_pulse_from_ctl_write: assert property (@(posedge clk) disable iff (rst)
        (|cnt_rst_o) |-> $past(req_valid && req_write
            && (32'(req_addr[ADDR_W-1:2]) >= NUM_CH)
            && (32'(req_addr[ADDR_W-1:2]) < 2*NUM_CH)));

    a_r10_one_channel: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_rst_o));

    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && req_write) |=> ($stable(clk_cfg_o) && $stable(ctl_cfg_o)
            && $stable(intv_o) && $stable(match_o) && $stable(evc_o)));

endmodule

bind itm_regbank itm_regbank_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VAL_W  (VAL_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .clk_cfg_o (clk_cfg_o),
    .ctl_cfg_o (ctl_cfg_o),
    .intv_o    (intv_o),
    .match_o   (match_o),
    .evc_o     (evc_o),
    .cnt_rst_o (cnt_rst_o)
);

// File: tb/test_itm_regbank.sv
module test_itm_regbank;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [11:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic [31:0]  rsp_rdata;
    logic [47:0]  cnt_val_i = '0;
    logic [47:0]  evt_cnt_i = '0;
    logic [17:0]  sts_set_i = '0;
    logic [17:0]  clk_cfg_o;
    logic [17:0]  ctl_cfg_o;
    logic [47:0]  intv_o;
    logic [143:0] match_o;
    logic [8:0]   evc_o;
    logic [2:0]   cnt_rst_o;
    logic [2:0]   irq_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    itm_regbank i_itm_regbank (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .cnt_val_i (cnt_val_i),
        .evt_cnt_i (evt_cnt_i),
        .sts_set_i (sts_set_i),
        .clk_cfg_o (clk_cfg_o),
        .ctl_cfg_o (ctl_cfg_o),
        .intv_o    (intv_o),
        .match_o   (match_o),
        .evc_o     (evc_o),
        .cnt_rst_o (cnt_rst_o),
        .irq_o     (irq_o)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NVEC = 33;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 12'h00C, 32'h0, 32'h21, 4'd3},          // R3 ctl reset ch0
        '{1'b0, 12'h010, 32'h0, 32'h21, 4'd3},          // R3 ctl reset ch1
        '{1'b0, 12'h014, 32'h0, 32'h21, 4'd3},          // R3 ctl reset ch2
        '{1'b0, 12'h000, 32'h0, 32'h0, 4'd3},           // R3 clock ctl reset
        '{1'b0, 12'h054, 32'h0, 32'h0, 4'd3},           // R3 status reset
        '{1'b1, 12'h000, 32'hFFFFFFFF, 32'h0, 4'd2},
        '{1'b0, 12'h000, 32'h0, 32'h3F, 4'd2},          // R2 clock mask
        '{1'b1, 12'h004, 32'h12, 32'h0, 4'd1},
        '{1'b0, 12'h004, 32'h0, 32'h12, 4'd1},          // R1 ch1 clock
        '{1'b0, 12'h008, 32'h0, 32'h0, 4'd1},           // R1 ch2 untouched
        '{1'b1, 12'h010, 32'hFF, 32'h0, 4'd2},
        '{1'b0, 12'h010, 32'h0, 32'h2F, 4'd2},          // R2 ctl mask
        '{1'b1, 12'h02C, 32'hABCD1234, 32'h0, 4'd2},
        '{1'b0, 12'h02C, 32'h0, 32'h1234, 4'd2},        // R2 interval mask
        '{1'b0, 12'h024, 32'h0, 32'h0, 4'd1},           // R1 ch0 interval
        '{1'b1, 12'h034, 32'h5555AAAA, 32'h0, 4'd1},
        '{1'b0, 12'h034, 32'h0, 32'hAAAA, 4'd1},        // R1 match1 ch1
        '{1'b0, 12'h030, 32'h0, 32'h0, 4'd1},           // R1 match1 ch0
        '{1'b1, 12'h044, 32'h7777, 32'h0, 4'd1},
        '{1'b0, 12'h044, 32'h0, 32'h7777, 4'd1},        // R1 match2 ch2
        '{1'b1, 12'h048, 32'hFFFFFFFF, 32'h0, 4'd2},
        '{1'b0, 12'h048, 32'h0, 32'hFFFF, 4'd2},        // R2 match3 mask
        '{1'b1, 12'h068, 32'hFFFF, 32'h0, 4'd2},
        '{1'b0, 12'h068, 32'h0, 32'h3F, 4'd2},          // R2 enable mask
        '{1'b1, 12'h06C, 32'hFF, 32'h0, 4'd2},
        '{1'b0, 12'h06C, 32'h0, 32'h7, 4'd2},           // R2 event ctl mask
        '{1'b0, 12'h01C, 32'h0, 32'h1234, 4'd9},        // R9 live count ch1
        '{1'b0, 12'h020, 32'h0, 32'hFACE, 4'd9},        // R9 live count ch2
        '{1'b0, 12'h080, 32'h0, 32'hBEEF, 4'd9},        // R9 event count ch2
        '{1'b0, 12'h078, 32'h0, 32'h0101, 4'd9},        // R9 event count ch0
        '{1'b0, 12'h084, 32'h0, 32'h0, 4'd9},           // R9 unmapped
        '{1'b0, 12'hFFC, 32'h0, 32'h0, 4'd9},           // R9 unmapped top
        '{1'b0, 12'h018, 32'h0, 32'h0, 4'd9}            // R9 live count ch0
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Request driven at a falling edge, sampled at the next rising edge;
    // results are read at the falling edge that follows.
    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        req_write = 1'b0;
        rd = rsp_rdata;
    endtask

    task automatic pulse_set(input int ch, input logic [5:0] bits);
        @(negedge clk);
        sts_set_i[ch*6 +: 6] = bits;
        @(negedge clk);
        sts_set_i = '0;
    endtask

    initial begin
        logic [31:0] rd;
        logic [296:0] snap;
        cnt_val_i = {16'hFACE, 16'h1234, 16'h0000};
        evt_cnt_i = {16'hBEEF, 16'h0000, 16'h0101};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R3 outputs after reset
        check("R3 ctl outputs", 32'(ctl_cfg_o), 32'({6'h21, 6'h21, 6'h21}));
        check("R3 irq", 32'(irq_o), 32'h0);
        check("R3 rsp_valid", 32'(rsp_valid), 32'h0);
        check("R3 cnt_rst", 32'(cnt_rst_o), 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus(VECS[i].wr, VECS[i].addr, VECS[i].data, rd);
            if (!VECS[i].wr) begin
                check($sformatf("R%0d vec %0d addr %h", VECS[i].req, i, VECS[i].addr),
                      rd, VECS[i].exp);
            end
        end

        // R11 configuration outputs
        check("R11 intv ch2", 32'(intv_o[32 +: 16]), 32'h1234);
        check("R11 match1 ch1", 32'(match_o[48 +: 16]), 32'hAAAA);
        check("R11 match2 ch2", 32'(match_o[112 +: 16]), 32'h7777);
        check("R11 match3 ch0", 32'(match_o[32 +: 16]), 32'hFFFF);
        check("R11 clk ch1", 32'(clk_cfg_o[6 +: 6]), 32'h12);
        check("R11 ctl ch1", 32'(ctl_cfg_o[6 +: 6]), 32'h2F);
        check("R11 evc ch0", 32'(evc_o[0 +: 3]), 32'h7);

        // R8 writes to read-only and unmapped words
        snap = {clk_cfg_o, ctl_cfg_o, intv_o, match_o, evc_o, cnt_rst_o, irq_o};
        bus(1'b1, 12'h01C, 32'hFFFF, rd);
        bus(1'b1, 12'h054, 32'h3F, rd);
        bus(1'b1, 12'h080, 32'hFFFF, rd);
        bus(1'b1, 12'h100, 32'hFFFF, rd);
        check("R8 outputs unchanged",
              32'(^{clk_cfg_o, ctl_cfg_o, intv_o, match_o, evc_o, cnt_rst_o, irq_o} != ^snap
                  || {clk_cfg_o, ctl_cfg_o, intv_o, match_o, evc_o, cnt_rst_o, irq_o} != snap),
              32'h0);
        bus(1'b0, 12'h054, 32'h0, rd);
        check("R8 status not written", rd, 32'h0);
        bus(1'b0, 12'h01C, 32'h0, rd);
        check("R8 count still live", rd, 32'h1234);

        // R7 and R5 on channel 0
        pulse_set(0, 6'h02);
        check("R7 irq0 masked", 32'(irq_o[0]), 32'h0);
        bus(1'b1, 12'h060, 32'h02, rd);
        check("R7 irq0 enabled", 32'(irq_o[0]), 32'h1);
        bus(1'b0, 12'h054, 32'h0, rd);
        check("R5 status read", rd, 32'h02);
        check("R5 irq0 after clear", 32'(irq_o[0]), 32'h0);
        bus(1'b0, 12'h054, 32'h0, rd);
        check("R5 status cleared", rd, 32'h0);

        // R6 set and clearing read in the same cycle on channel 1
        pulse_set(1, 6'h01);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 12'h058;
        sts_set_i[6 +: 6] = 6'h10;
        @(negedge clk);
        req_valid = 1'b0;
        sts_set_i = '0;
        check("R6 read returns old", rsp_rdata, 32'h01);
        bus(1'b0, 12'h058, 32'h0, rd);
        check("R6 new bit kept", rd, 32'h10);

        // R7 on channel 2 (enable 0x3F)
        pulse_set(2, 6'h20);
        check("R7 irq2 raised", 32'(irq_o), 32'h4);

        // R10 counter reset pulse on channel 2
        bus(1'b1, 12'h014, 32'h10, rd);
        check("R10 pulse ch2", 32'(cnt_rst_o), 32'h4);
        @(negedge clk);
        check("R10 pulse ends", 32'(cnt_rst_o), 32'h0);
        bus(1'b0, 12'h014, 32'h0, rd);
        check("R10 bit4 not stored", rd, 32'h0);

        // R4 response timing
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_addr  = 12'h004;
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 rsp_valid after read", 32'(rsp_valid), 32'h1);
        @(negedge clk);
        check("R4 rsp_valid drops", 32'(rsp_valid), 32'h0);
        bus(1'b1, 12'h004, 32'h3, rd);
        check("R4 no rsp on write", 32'(rsp_valid), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule